// File: doc/BRIEF.md
# Codec-to-Controller Serial Frame Transmitter

This block is the transmit half of a codec's serial link toward its digital controller. Each frame is 256 bit periods long and begins when the controller's frame-sync input goes from low to high. The block sends a 16-bit tag slot and then twelve 20-bit slots, one bit per bit-clock rising edge, most significant bit first. The controller samples the line on the falling edge.

The tag marks the codec as ready and flags which slots carry new content. Slots 1 and 2 return a register read: the echoed 7-bit register index and the 16-bit value, in the frame after the request. Slots 3 and 4 carry the newest left and right 18-bit record samples. All other slots and every reserved bit are sent as zero.

Register logic delivers the read response on a valid/ready stream. A response that has been accepted is held until the next frame start sends it. Until then ready stays low, and the source must keep valid and its payload steady. Each record-sample stream is also valid/ready, but ready is always high. A newer sample replaces an older one that has not yet been sent. A transfer that completes on the same clock edge as a frame start goes into the following frame.

Top module: `acl_upstream_ser`

## Requirements
- R1: After reset and before the first frame start, `sd_out` is 0 and `rsp_ready`, `smp_l_ready` and `smp_r_ready` are 1.
- R2: A frame start is a rising edge of `clk` at which `sync` is 1 after being 0 at the previous edge. The first frame bit is on `sd_out` after that edge. Bits 1 to 255 follow, one per following edge. `sync` staying high for any number of cycles does not restart the frame.
- R3: Tag bit 15 (frame bit 0) equals `codec_ready` sampled at the frame-start edge. Tag bits 14 and 13 (frame bits 1, 2) are both 1 when a read response is sent. Tag bit 12 (frame bit 3) flags the left record slot and tag bit 11 (frame bit 4) flags the right one. Tag bits 10:0 are 0.
- R4: When a response is sent, slot 1 carries the register index in its bits 18:12, and slot 2 carries the register value in its bits 19:4. Slot 1 bits 19 and 11:0 and slot 2 bits 3:0 are 0.
- R5: An accepted response is held with `rsp_ready` low until the next frame start. That frame sends it, and `rsp_ready` returns to 1 after that edge. `rsp_ready` rises at no other time.
- R6: Slot 3 (left) and slot 4 (right) carry an 18-bit sample in bits 19:2, with bits 1:0 zero. A record slot is flagged and filled only if a sample was accepted after the previous frame start. When several were accepted, the last one is sent.
- R7: Slots 5 to 12 are all zero, as are the bits after bit 255 until the next frame start.
- R8: A slot whose tag flag is 0 (no pending response, or no new sample) is sent as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync from the controller, synchronous to `clk` |
| codec_ready | input | 1 | Codec-ready flag, sampled at each frame start |
| rsp_valid | input | 1 | Read response offered |
| rsp_ready | output | 1 | Response holding slot is free |
| rsp_addr | input | ADDR_W | Index of the register that was read |
| rsp_data | input | REG_W | Value of the register that was read |
| smp_l_valid | input | 1 | Left record sample offered |
| smp_l_ready | output | 1 | Left sample accepted (always 1) |
| smp_l_data | input | SMP_W | Left record sample |
| smp_r_valid | input | 1 | Right record sample offered |
| smp_r_ready | output | 1 | Right sample accepted (always 1) |
| smp_r_data | input | SMP_W | Right record sample |
| sd_out | output | 1 | Serial frame data, MSB first |

## Verification
The bench builds the block with its defaults: a 7-bit index, a 16-bit value, 18-bit samples and twelve data slots. This gives a full 256-bit frame, so every slot boundary, every reserved bit and the zero tail are observed bit by bit. Sync pulses of random length from one cycle to 200 cycles test that a long-held sync does not restart a frame. A response offered while one is already held must stall across the frame boundary. A sample offered on the frame-start edge itself shows the edge rule for transfers.

// File: rtl/acl_up_pkg.sv
package acl_up_pkg;
  localparam int TAG_W  = 16;
  localparam int SLOT_W = 20;

  // leading tag flags, placed from the tag MSB downward
  typedef struct packed {
    logic ready;
    logic addr_v;
    logic data_v;
    logic left_v;
    logic right_v;
  } tag_flags_t;

  localparam int FLAG_W = $bits(tag_flags_t);
endpackage

// File: rtl/acl_up_hold.sv
module acl_up_hold #(
  parameter int W         = 8,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] data_q;

  generate
    if (OVERWRITE) begin : g_newest_wins
      assign in_ready = 1'b1;
    end else begin : g_hold_one
      assign in_ready = ~full_q;
    end
  endgenerate

  // a transfer on the frame-start edge lands after the take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/acl_up_assemble.sv
module acl_up_assemble
  import acl_up_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int REG_W   = 16,
  parameter int SMP_W   = 18,
  parameter int FRAME_W = 256
) (
  input  logic                  ready,
  input  logic                  rsp_v,
  input  logic [ADDR_W-1:0]     rsp_addr,
  input  logic [REG_W-1:0]      rsp_data,
  input  logic [1:0]            smp_v,
  input  logic [1:0][SMP_W-1:0] smp,
  output logic [FRAME_W-1:0]    frame
);
  localparam int S1_TOP = FRAME_W - 1 - TAG_W;
  localparam int S2_TOP = S1_TOP - SLOT_W;
  localparam int S3_TOP = S2_TOP - SLOT_W;

  tag_flags_t flags;

  always_comb begin
    flags.ready   = ready;
    flags.addr_v  = rsp_v;
    flags.data_v  = rsp_v;
    flags.left_v  = smp_v[0];
    flags.right_v = smp_v[1];

    frame = '0;
    frame[FRAME_W-1 -: FLAG_W] = flags;
    if (rsp_v) begin
      frame[S1_TOP-1 -: ADDR_W] = rsp_addr;
      frame[S2_TOP -: REG_W]    = rsp_data;
    end
    for (int ch = 0; ch < 2; ch++) begin
      if (smp_v[ch]) frame[S3_TOP - ch*SLOT_W -: SMP_W] = smp[ch];
    end
  end
endmodule

// File: rtl/acl_up_shift.sv
module acl_up_shift #(
  parameter int FRAME_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic [FRAME_W-1:0] frame,
  output logic               start,
  output logic               sd_out
);
  logic               sync_q;
  logic               sd_q;
  logic [FRAME_W-2:0] rest;

  assign start = sync & ~sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      sd_q   <= 1'b0;
      rest   <= '0;
    end else begin
      sync_q <= sync;
      if (start) begin
        sd_q <= frame[FRAME_W-1];
        rest <= frame[FRAME_W-2:0];
      end else begin
        sd_q <= rest[FRAME_W-2];
        rest <= {rest[FRAME_W-3:0], 1'b0};
      end
    end
  end

  assign sd_out = sd_q;
endmodule

// File: rtl/acl_upstream_ser.sv
module acl_upstream_ser
  import acl_up_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_W     = 16,
  parameter int SMP_W     = 18,
  parameter int NUM_SLOTS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              codec_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [REG_W-1:0]  rsp_data,
  input  logic              smp_l_valid,
  output logic              smp_l_ready,
  input  logic [SMP_W-1:0]  smp_l_data,
  input  logic              smp_r_valid,
  output logic              smp_r_ready,
  input  logic [SMP_W-1:0]  smp_r_data,
  output logic              sd_out
);
  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int RSP_W   = ADDR_W + REG_W;

  logic                  frame_start;
  logic                  rsp_full;
  logic [RSP_W-1:0]      rsp_held;
  logic [1:0]            smp_in_v;
  logic [1:0]            smp_in_r;
  logic [1:0][SMP_W-1:0] smp_in_d;
  logic [1:0]            smp_full;
  logic [1:0][SMP_W-1:0] smp_held;
  logic [FRAME_W-1:0]    frame;

  acl_up_hold #(.W(RSP_W), .OVERWRITE(1'b0)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rsp_valid), .in_ready(rsp_ready),
    .in_data({rsp_addr, rsp_data}),
    .take(frame_start), .full(rsp_full), .data(rsp_held)
  );

  assign smp_in_v    = {smp_r_valid, smp_l_valid};
  assign smp_in_d[0] = smp_l_data;
  assign smp_in_d[1] = smp_r_data;
  assign smp_l_ready = smp_in_r[0];
  assign smp_r_ready = smp_in_r[1];

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_rec
      acl_up_hold #(.W(SMP_W), .OVERWRITE(1'b1)) u_smp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(smp_in_v[ch]), .in_ready(smp_in_r[ch]),
        .in_data(smp_in_d[ch]),
        .take(frame_start), .full(smp_full[ch]), .data(smp_held[ch])
      );
    end
  endgenerate

  acl_up_assemble #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .SMP_W(SMP_W), .FRAME_W(FRAME_W)
  ) u_asm (
    .ready(codec_ready),
    .rsp_v(rsp_full),
    .rsp_addr(rsp_held[RSP_W-1 -: ADDR_W]),
    .rsp_data(rsp_held[REG_W-1:0]),
    .smp_v(smp_full),
    .smp(smp_held),
    .frame(frame)
  );

  acl_up_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sync(sync), .frame(frame),
    .start(frame_start), .sd_out(sd_out)
  );
endmodule

// File: rtl/acl_upstream_ser_chk.sv
module acl_upstream_ser_chk #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int ADDR_W  = 7,
  parameter int REG_W   = 16,
  parameter int SMP_W   = 18
) (
  input logic clk,
  input logic rst_n,
  input logic sd_out,
  input logic codec_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic frame_start
);
  logic seen;
  int   pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pos  <= 0;
    end else if (frame_start) begin
      seen <= 1'b1;
      pos  <= 0;
    end else if (seen && pos < FRAME_W - 1) begin
      pos <= pos + 1;
    end
  end

  function automatic logic is_reserved(int p);
    int s;
    int b;
    if (p < TAG_W) return p >= 5;
    s = (p - TAG_W) / SLOT_W;
    b = SLOT_W - 1 - ((p - TAG_W) % SLOT_W);
    case (s)
      0:       return (b == SLOT_W - 1) || (b < SLOT_W - 1 - ADDR_W);
      1:       return b < SLOT_W - REG_W;
      2, 3:    return b < SLOT_W - SMP_W;
      default: return 1'b1;
    endcase
  endfunction

  // R1
  a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !sd_out);

  // R3
  a_r3_ready_is_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pos == 0) |-> (sd_out == $past(codec_ready)));

  // R7 and reserved fields of R3, R4, R6
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && is_reserved(pos)) |-> !sd_out);

  // R5
  a_r5_held_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !frame_start) |=> !rsp_ready);

  // R5
  a_r5_release_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(frame_start));
endmodule

bind acl_upstream_ser acl_upstream_ser_chk #(
  .FRAME_W(FRAME_W), .TAG_W(acl_up_pkg::TAG_W), .SLOT_W(acl_up_pkg::SLOT_W),
  .ADDR_W(ADDR_W), .REG_W(REG_W), .SMP_W(SMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_out(sd_out), .codec_ready(codec_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .frame_start(frame_start)
);

// File: tb/acl_upstream_ser_tb.sv
module acl_upstream_ser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        codec_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [6:0]  rsp_addr = '0;
  logic [15:0] rsp_data = '0;
  logic        smp_l_valid = 1'b0;
  logic        smp_l_ready;
  logic [17:0] smp_l_data = '0;
  logic        smp_r_valid = 1'b0;
  logic        smp_r_ready;
  logic [17:0] smp_r_data = '0;
  logic        sd_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of what the next frame must carry
  bit          m_rd_full = 0, m_l_full = 0, m_r_full = 0;
  logic [6:0]  m_rd_a = '0;
  logic [15:0] m_rd_d = '0;
  logic [17:0] m_l_d = '0, m_r_d = '0;
  bit          rd_acc = 0, l_acc = 0, r_acc = 0;

  always #5 clk = ~clk;

  acl_upstream_ser u_dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .smp_l_valid(smp_l_valid), .smp_l_ready(smp_l_ready), .smp_l_data(smp_l_data),
    .smp_r_valid(smp_r_valid), .smp_r_ready(smp_r_ready), .smp_r_data(smp_r_data),
    .sd_out(sd_out)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [255:0] expect_frame(bit cr, bit rv, logic [6:0] a, logic [15:0] d,
                                                bit lv, logic [17:0] ld, bit rrv, logic [17:0] rd);
    logic [255:0] f = '0;
    f[255] = cr; f[254] = rv; f[253] = rv; f[252] = lv; f[251] = rrv;
    if (rv) begin f[238:232] = a; f[219:204] = d; end
    if (lv)  f[199:182] = ld;
    if (rrv) f[179:162] = rd;
    return f;
  endfunction

  // completes transfers that happened at the previous rising edge
  task automatic finish_xfers();
    if (rd_acc) begin m_rd_full = 1; m_rd_a = rsp_addr; m_rd_d = rsp_data; rsp_valid = 0; rd_acc = 0; end
    if (l_acc) begin m_l_full = 1; m_l_d = smp_l_data; smp_l_valid = 0; l_acc = 0; end
    if (r_acc) begin m_r_full = 1; m_r_d = smp_r_data; smp_r_valid = 0; r_acc = 0; end
  endtask

  // checks ready and marks the transfers the next rising edge completes
  task automatic mark_xfers();
    if (rsp_valid) begin
      chk(rsp_ready == !m_rd_full, "R5 rsp_ready", 64'(rsp_ready), 64'(!m_rd_full));
      if (!m_rd_full) rd_acc = 1;
    end
    if (smp_l_valid) begin
      chk(smp_l_ready == 1'b1, "R6 smp_l_ready", 64'(smp_l_ready), 64'd1);
      l_acc = 1;
    end
    if (smp_r_valid) begin
      chk(smp_r_ready == 1'b1, "R6 smp_r_ready", 64'(smp_r_ready), 64'd1);
      r_acc = 1;
    end
  endtask

  task automatic run_frame(input bit cr, input int rd_a, input int rd_b, input int l_a,
                           input int l_b, input int r_a, input bit edge_l, input int sync_len);
    logic [255:0] cap, exp;
    codec_ready = cr;
    exp = expect_frame(cr, m_rd_full, m_rd_a, m_rd_d, m_l_full, m_l_d, m_r_full, m_r_d);
    m_rd_full = 0; m_l_full = 0; m_r_full = 0;
    if (edge_l && !smp_l_valid) begin
      smp_l_valid = 1; smp_l_data = 18'($urandom);
      chk(smp_l_ready == 1'b1, "R6 smp_l_ready at start", 64'(smp_l_ready), 64'd1);
      l_acc = 1;
    end
    sync = 1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cap[255-i] = sd_out;
      finish_xfers();
      if (i == 3) codec_ready = 1'($urandom);
      if ((i == rd_a || i == rd_b) && !rsp_valid) begin
        rsp_valid = 1; rsp_addr = 7'($urandom); rsp_data = 16'($urandom);
      end
      if ((i == l_a || i == l_b) && !smp_l_valid) begin
        smp_l_valid = 1; smp_l_data = 18'($urandom);
      end
      if (i == r_a && !smp_r_valid) begin
        smp_r_valid = 1; smp_r_data = 18'($urandom);
      end
      mark_xfers();
      if (i == sync_len - 1) sync = 0;
    end
    chk(cap[255:240] == exp[255:240], "R3 tag slot", 64'(cap[255:240]), 64'(exp[255:240]));
    chk(cap[239:200] == exp[239:200], exp[254] ? "R4 response slots" : "R8 response slots zero",
        64'(cap[239:200]), 64'(exp[239:200]));
    chk(cap[199:180] == exp[199:180], exp[252] ? "R6 left slot" : "R8 left slot zero",
        64'(cap[199:180]), 64'(exp[199:180]));
    chk(cap[179:160] == exp[179:160], exp[251] ? "R6 right slot" : "R8 right slot zero",
        64'(cap[179:160]), 64'(exp[179:160]));
    chk(cap[159:0] == '0, "R7 unused slots", 64'($countones(cap[159:0])), 64'd0);
    chk(cap == exp, "R2 whole frame order", 64'($countones(cap ^ exp)), 64'd0);
  endtask

  function automatic int pick(int odds);
    if (($urandom % 100) < odds) return 20 + int'($urandom % 200);
    return -1;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(sd_out == 1'b0, "R1 idle output", 64'(sd_out), 64'd0);
    end
    chk(rsp_ready == 1'b1, "R1 rsp_ready after reset", 64'(rsp_ready), 64'd1);
    chk(smp_l_ready && smp_r_ready, "R1 sample ready after reset",
        64'({smp_l_ready, smp_r_ready}), 64'd3);

    // directed: empty frame, then one of each, then stall and newest-wins
    run_frame(0, -1, -1, -1, -1, -1, 0, 16);
    run_frame(1, 50, -1, 60, -1, 70, 0, 16);
    run_frame(1, 40, 80, 90, 130, -1, 0, 255 - 55);
    run_frame(0, -1, -1, -1, -1, -1, 0, 1);
    // sample offered on the start edge belongs to the following frame
    run_frame(1, -1, -1, -1, -1, -1, 1, 8);
    run_frame(1, -1, -1, -1, -1, -1, 0, 8);

    for (int f = 0; f < 30; f++) begin
      run_frame(1'($urandom), pick(50), pick(25), pick(50), pick(30), pick(50),
                (($urandom % 4) == 0), 1 + int'($urandom % 200));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule